// File: doc/BRIEF.md
# Consecutive Zero-Sample Mute Flag Detector

This block watches the sample streams feeding three stereo DAC channels and raises a single mute flag when the selected channels have been silent for a long enough run. Each channel takes its left and right samples together as one frame. A frame counts as silent only when both samples are all-zero. Each channel keeps a small state machine and a saturating counter of consecutive silent frames. Its zero flag rises once the run reaches `RUN_LEN` frames, which is 1024 by default.

A 2-bit selector sets what the output reports. Code 00 reports the AND of all channel flags. Codes 01, 10 and 11 report the flag of channel 1, 2 or 3. The output is active high. The selector acts combinationally on the current flags and never disturbs the counters, so it can change while samples stream in.

Each channel tracker has three states:
- `ST_LIVE`: the last frame was non-silent, or the tracker was just reset.
- `ST_COUNT`: a silent run is in progress but shorter than `RUN_LEN`.
- `ST_SILENT`: the run has reached `RUN_LEN` and the flag is set.

The transitions are:
- LIVE→COUNT on a silent frame.
- LIVE→SILENT on a silent frame when `RUN_LEN` is 1.
- COUNT→COUNT on a silent frame that leaves the run short.
- COUNT→SILENT on the silent frame that completes the run.
- COUNT→LIVE on a non-silent frame.
- SILENT→SILENT on further silent frames.
- SILENT→LIVE on a non-silent frame.

Frames are only taken on cycles with the strobe high.

Top module: `mute_flag_detect`

## Requirements
- R1: A frame is silent only when both its left and right samples are zero. A frame with only one zero side counts as non-silent.
- R2: A channel's flag is set after the clock edge that takes the RUN_LEN-th consecutive silent frame on that channel, and not after any earlier one.
- R3: A strobed non-silent frame clears that channel's run counter and drops its flag at that same clock edge.
- R4: The run counter saturates at RUN_LEN, and the flag stays set for as long as silent frames continue.
- R5: On cycles with the strobe low, no counter or flag changes, whatever the sample inputs carry.
- R6: Reset (active-low, asynchronous) clears every counter and flag, so the output reads low.
- R7: Selector code 00 drives the output high only when every channel's flag is set.
- R8: Selector codes 01, 10 and 11 drive the output with the flag of channel 1, 2 and 3 respectively. Channel 1 occupies the least significant slice of each sample bus.
- R9: A selector change updates the output in the same cycle from the current flags and restarts no counter.
- R10: The channels count independently. A non-silent frame on one channel does not affect another channel's run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_strobe | input | 1 | High on cycles that carry a new frame |
| left_bus | input | NUM_CH*SAMPLE_W | Left samples, channel 1 in the low slice |
| right_bus | input | NUM_CH*SAMPLE_W | Right samples, channel 1 in the low slice |
| zero_sel | input | 2 | Output selector: 00 all channels, 01..11 one channel |
| mute_flag | output | 1 | Active-high mute flag |

## Verification
The bench builds the block with its default values: three channels, 24-bit samples and a run length of 1024. This keeps the real threshold under test, including the frame at 1023 that must not set the flag, the frame at 1024 that must, and saturation beyond it. These are reached with strobes on every cycle and with strobe gaps. At this run length every channel can be driven into and out of the silent state several times, and each selector code can be swept against a mix of set and clear flags, well inside the cycle budget.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    // Per-channel run tracker states
    typedef enum logic [1:0] {
        ST_LIVE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SILENT = 2'd2
    } run_state_e;

    // Width needed to hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((2 ** w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/mfd_zero_run_tracker.sv
module mfd_zero_run_tracker
    import mfd_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic                zero_flag
);

    localparam int unsigned CNT_W = cnt_width(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam bit   ONE_FRAME_RUN        = (RUN_LEN == 1);

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] run_cnt_q, run_cnt_d;
    logic             frame_zero;

    // A frame is silent only when both sides are zero
    assign frame_zero = (left_smp == '0) && (right_smp == '0);

    // Next-state and counter logic
    always_comb begin
        st_d      = st_q;
        run_cnt_d = run_cnt_q;
        if (strobe) begin
            unique case (st_q)
                ST_LIVE: begin
                    if (frame_zero) begin
                        if (ONE_FRAME_RUN) begin
                            st_d      = ST_SILENT;
                            run_cnt_d = CNT_FULL;
                        end else begin
                            st_d      = ST_COUNT;
                            run_cnt_d = CNT_ONE;
                        end
                    end
                end
                ST_COUNT: begin
                    if (!frame_zero) begin
                        st_d      = ST_LIVE;
                        run_cnt_d = '0;
                    end else if (run_cnt_q == CNT_LAST) begin
                        st_d      = ST_SILENT;
                        run_cnt_d = CNT_FULL;
                    end else begin
                        run_cnt_d = run_cnt_q + CNT_ONE;
                    end
                end
                ST_SILENT: begin
                    if (!frame_zero) begin
                        st_d      = ST_LIVE;
                        run_cnt_d = '0;
                    end
                end
                default: begin
                    st_d      = ST_LIVE;
                    run_cnt_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_LIVE;
        end else begin
            st_q <= st_d;
        end
    end

    // Run counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else begin
            run_cnt_q <= run_cnt_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            ST_SILENT: zero_flag = 1'b1;
            ST_LIVE,
            ST_COUNT:  zero_flag = 1'b0;
            default:   zero_flag = 1'b0;
        endcase
    end

    AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !frame_zero) |=> (!zero_flag && run_cnt_q == '0)); // R3
    AST_FLAG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> $past(strobe && frame_zero)); // R2
    AST_FLAG_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> (run_cnt_q == CNT_FULL)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt_q <= CNT_FULL); // R4
    AST_SILENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && strobe && frame_zero) |=> zero_flag); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(run_cnt_q) && $stable(zero_flag))); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (run_cnt_q == '0 && !zero_flag)); // R6

endmodule

// File: rtl/mfd_flag_select.sv
module mfd_flag_select #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [NUM_CH-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              flag_out
);

    // Code 0 reports all channels; code k reports channel k
    always_comb begin
        flag_out = 1'b0;
        if (sel == '0) begin
            flag_out = &flags;
        end else begin
            for (int k = 1; k <= int'(NUM_CH); k++) begin
                if (sel == SEL_W'(k)) flag_out = flags[k-1];
            end
        end
    end

endmodule

// File: rtl/mute_flag_detect.sv
module mute_flag_detect
    import mfd_pkg::*;
#(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_strobe,
    input  logic [NUM_CH*SAMPLE_W-1:0]   left_bus,
    input  logic [NUM_CH*SAMPLE_W-1:0]   right_bus,
    input  logic [1:0]                   zero_sel,
    output logic                         mute_flag
);

    localparam int unsigned SEL_W = 2;

    logic [NUM_CH-1:0] ch_flag;

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        mfd_zero_run_tracker #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe    (smp_strobe),
            .left_smp  (left_bus[c*SAMPLE_W +: SAMPLE_W]),
            .right_smp (right_bus[c*SAMPLE_W +: SAMPLE_W]),
            .zero_flag (ch_flag[c])
        );
    end

    mfd_flag_select #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) u_sel (
        .flags    (ch_flag),
        .sel      (zero_sel),
        .flag_out (mute_flag)
    );

    AST_ALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_sel == 2'b00 && mute_flag) |-> (ch_flag == '1)); // R7
    AST_CH1_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_sel == 2'b01) |-> (mute_flag == ch_flag[0])); // R8
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mute_flag); // R6

endmodule

// File: tb/tb_mute_flag_detect.sv
`timescale 1ns/1ps
module tb_mute_flag_detect;

    localparam int NCH = 3;
    localparam int SW  = 24;
    localparam int RUN = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_strobe = 1'b0;
    logic [NCH*SW-1:0] left_bus = '0;
    logic [NCH*SW-1:0] right_bus = '0;
    logic [1:0]        zero_sel = 2'b00;
    logic              mute_flag;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R6";
    int    ref_cnt [NCH];

    always #4 clk = ~clk; // 125 MHz

    mute_flag_detect #(.NUM_CH(NCH), .SAMPLE_W(SW), .RUN_LEN(RUN)) dut (
        .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe),
        .left_bus(left_bus), .right_bus(right_bus),
        .zero_sel(zero_sel), .mute_flag(mute_flag)
    );

    // Behavioural reference: run lengths per channel
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) ref_cnt[c] = 0;
        end else if (smp_strobe) begin
            for (int c = 0; c < NCH; c++) begin
                if (left_bus[c*SW +: SW] == 0 && right_bus[c*SW +: SW] == 0)
                    ref_cnt[c] = (ref_cnt[c] >= RUN) ? RUN : ref_cnt[c] + 1;
                else
                    ref_cnt[c] = 0;
            end
        end
    end

    function automatic bit expect_flag(input logic [1:0] s);
        bit all_set;
        all_set = 1'b1;
        for (int c = 0; c < NCH; c++) if (ref_cnt[c] < RUN) all_set = 1'b0;
        if (s == 2'b00) return all_set;
        return ref_cnt[s-1] >= RUN;
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mute_flag=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (checking && rst_n && !done) check(cur_req, mute_flag, expect_flag(zero_sel));
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic set_ch(input int ch, input logic [SW-1:0] l, input logic [SW-1:0] r);
        left_bus[ch*SW +: SW]  = l;
        right_bus[ch*SW +: SW] = r;
    endtask

    task automatic zero_frames(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            smp_strobe = 1'b1;
            step();
            if (gaps && (i % 3 == 1)) begin
                smp_strobe = 1'b0;
                step();
            end
        end
        smp_strobe = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_up();
    end

    initial begin
        // R6: reset state
        repeat (4) step();
        rst_n = 1'b1;
        step();
        check("R6", mute_flag, 1'b0);
        checking = 1'b1;

        // R2: threshold at exactly RUN frames on channel 1
        cur_req = "R2";
        zero_sel = 2'b01;
        zero_frames(RUN - 1, 1'b0);
        #1 check("R2", mute_flag, 1'b0);
        zero_frames(1, 1'b0);
        #1 check("R2", mute_flag, 1'b1);

        // R4: saturation, flag holds; R7 all channels set
        cur_req = "R4";
        zero_frames(40, 1'b1);
        zero_sel = 2'b00;
        #1 check("R7", mute_flag, 1'b1);

        // R1: one-sided zero counts as non-silent on channel 2
        cur_req = "R1";
        set_ch(1, 24'd0, 24'd5);
        smp_strobe = 1'b1;
        step();
        smp_strobe = 1'b0;
        set_ch(1, 24'd0, 24'd0);
        zero_sel = 2'b10;
        #1 check("R1", mute_flag, 1'b0);
        zero_sel = 2'b00;
        #1 check("R7", mute_flag, 1'b0);
        zero_sel = 2'b01;
        #1 check("R10", mute_flag, 1'b1);

        // R5: no strobe, nonzero data ignored
        cur_req = "R5";
        set_ch(0, 24'hABCDEF, 24'h1);
        repeat (20) step();
        #1 check("R5", mute_flag, 1'b1);

        // R3: strobed nonzero clears channel 1
        cur_req = "R3";
        smp_strobe = 1'b1;
        step();
        smp_strobe = 1'b0;
        #1 check("R3", mute_flag, 1'b0);
        set_ch(0, 24'd0, 24'd0);

        // R8: channel 3 flag reported on code 11
        cur_req = "R8";
        zero_sel = 2'b11;
        #1 check("R8", mute_flag, 1'b1);

        // R9: selector sweep while runs build up with gaps
        cur_req = "R9";
        for (int i = 0; i < RUN + 60; i++) begin
            zero_sel = 2'(i % 4);
            smp_strobe = (i % 5 != 4);
            step();
        end
        smp_strobe = 1'b0;

        // R10: channel 3 disturbed periodically, others unaffected
        cur_req = "R10";
        for (int i = 0; i < 3 * RUN; i++) begin
            zero_sel = 2'(i % 4);
            if (i % 700 == 699) set_ch(2, 24'h800000, 24'd0);
            else set_ch(2, 24'd0, 24'd0);
            smp_strobe = 1'b1;
            step();
        end
        smp_strobe = 1'b0;
        set_ch(2, 24'd0, 24'd0);
        zero_sel = 2'b01;
        #1 check("R10", mute_flag, 1'b1);

        // R6: reset in the middle of a silent run
        cur_req = "R6";
        checking = 1'b0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        #1 check("R6", mute_flag, 1'b0);
        checking = 1'b1;
        zero_frames(RUN - 1, 1'b0);
        #1 check("R2", mute_flag, 1'b0);
        zero_frames(1, 1'b0);
        #1 check("R2", mute_flag, 1'b1);

        step();
        finish_up();
    end

endmodule